// File: doc/BRIEF.md
# Lane-Configurable SIMD Register Unit

This block pairs a 32-entry, 128-bit vector register file with an integer execution stage that works on all lanes at once. Each operation names a destination register and two source registers. It also carries an arrangement code that sets the element width and the element count. All elements of one operation share the same width. The supported operations are:

- lane-wise add;
- lane-wise multiply;
- multiply of every lane by one indexed element of the second source;
- insertion of a scalar into one element of the destination.

A result is committed at the clock edge that samples the operation. An operation that cannot be carried out raises a one-cycle error pulse and changes nothing. A registered debug port reads out any register, so a host or testbench can observe the full architectural state.

Top module: `simd_regunit`

## Requirements
- R1: After synchronous reset every register holds zero, and a debug read of any register returns zero.
- R2: `op_arr[4:3]` is the element size code (0: 8 bits, 1: 16, 2: 32, 3: 64) and `op_arr[2:0]` is log2 of the element count. An operation is legal only if width × count is 128 or 64 bits. An illegal arrangement makes `err` high in the cycle after the operation and leaves every register unchanged.
- R3: Opcode 0 (add) writes, for every lane k, the sum of lane k of source n and lane k of source m modulo 2^width. No carry crosses a lane boundary.
- R4: Opcode 1 (multiply) writes, for every lane k, the low width bits of the product of lane k of the two sources.
- R5: Opcode 2 (by-element multiply) multiplies every lane of source n by element `op_idx` of source m. An index not below the element count is an error, handled as in R2.
- R6: Opcode 3 (insert) replaces element `op_idx` of the destination with the low width bits of `op_scalar` and keeps every other destination bit. An index not below the element count is an error, handled as in R2.
- R7: For opcodes 0 to 2 with a 64-bit total length, destination bits 127:64 are written as zero.
- R8: Element k of width w occupies bits k·w+w-1 down to k·w. Elements are numbered from the least significant end.
- R9: A legal operation is written at the clock edge that samples `op_valid`. A source read or debug read in the next cycle sees the new value. `dbg_data` shows, after each edge, the register named by `dbg_addr` at that edge, taken before that edge's write.
- R10: `err` is low in the cycle after a cycle with no operation or with a legal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 0 add, 1 multiply, 2 by-element multiply, 3 insert |
| op_arr | input | 5 | Size code [4:3], log2 element count [2:0] |
| op_rd | input | 5 | Destination register |
| op_rn | input | 5 | First source register |
| op_rm | input | 5 | Second source register |
| op_idx | input | 4 | Element index for by-element multiply and insert |
| op_scalar | input | 64 | Value inserted by opcode 3 |
| dbg_addr | input | 5 | Debug read register |
| dbg_data | output | 128 | Registered debug read data |
| err | output | 1 | Registered error pulse |

## Verification
The bench builds the unit at its default 128-bit width and 32-register depth. At that size all four element sizes occur at both vector lengths, and 8-bit lanes exercise the full 4-bit index range. The 5-bit arrangement field has enough room to produce both too-short (32-bit) and too-long (256 bits and beyond) totals, which reaches the error path with real out-of-range combinations. A behavioural model mirrors the whole register file. Its predictions are compared with the debug port and the error flag every cycle, through directed lane-carry, narrowing, broadcast and insertion cases and a long random run.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [1:0] {
    OP_ADD  = 2'd0,
    OP_MUL  = 2'd1,
    OP_MULE = 2'd2,
    OP_INS  = 2'd3
  } simd_op_e;

  function automatic int elem_bits(input logic [1:0] sz);
    return 8 << sz;
  endfunction

  function automatic int arr_bits(input logic [1:0] sz, input logic [2:0] lg);
    return elem_bits(sz) << lg;
  endfunction

  function automatic logic uses_index(input simd_op_e op);
    return (op == OP_MULE) || (op == OP_INS);
  endfunction

endpackage

// File: rtl/simd_vrf.sv
module simd_vrf #(
  parameter int VW    = 128,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [VW-1:0] wdata,
  input  logic [AW-1:0] ra_addr,
  output logic [VW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [VW-1:0] rb_data,
  input  logic [AW-1:0] rc_addr,
  output logic [VW-1:0] rc_data,
  input  logic [AW-1:0] dbg_addr,
  output logic [VW-1:0] dbg_data
);

  logic [VW-1:0] mem [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        mem[r] <= '0;
      end else if (we && (waddr == AW'(r))) begin
        mem[r] <= wdata;
      end
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rc_data = mem[rc_addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_data <= '0;
    end else begin
      dbg_data <= mem[dbg_addr];
    end
  end

endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int VW   = 128,
  parameter int IDXW = 4,
  parameter int SW   = 64
) (
  input  simd_op_e        op,
  input  logic [1:0]      size,
  input  logic            narrow,
  input  logic [IDXW-1:0] idx,
  input  logic [SW-1:0]   scalar,
  input  logic [VW-1:0]   src_a,
  input  logic [VW-1:0]   src_b,
  input  logic [VW-1:0]   dst_old,
  output logic [VW-1:0]   result
);

  localparam int NSZ = 4;

  logic [VW-1:0] per_size [NSZ];

  for (genvar s = 0; s < NSZ; s++) begin : g_size
    localparam int W  = 8 << s;
    localparam int N  = VW / W;
    localparam int LG = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0][W-1:0] av, bv, dv, rv;
    logic [LG-1:0]       isel;
    logic [W-1:0]        bsel;

    assign av   = src_a;
    assign bv   = src_b;
    assign dv   = dst_old;
    assign isel = idx[LG-1:0];
    assign bsel = bv[isel];

    always_comb begin
      rv = dv;
      if (op == OP_INS) begin
        rv[isel] = scalar[W-1:0];
      end else begin
        for (int k = 0; k < N; k++) begin
          unique case (op)
            OP_ADD:  rv[k] = av[k] + bv[k];
            OP_MUL:  rv[k] = av[k] * bv[k];
            default: rv[k] = av[k] * bsel;
          endcase
        end
      end
    end

    assign per_size[s] = rv;
  end

  always_comb begin
    result = per_size[size];
    if (narrow && (op != OP_INS)) begin
      result[VW-1:VW/2] = '0;
    end
  end

endmodule

// File: rtl/simd_regunit.sv
module simd_regunit
  import simd_pkg::*;
#(
  parameter int VW    = 128,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int IDXW = $clog2(VW / 8),
  localparam int SW   = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            op_valid,
  input  logic [1:0]      op_code,
  input  logic [4:0]      op_arr,
  input  logic [AW-1:0]   op_rd,
  input  logic [AW-1:0]   op_rn,
  input  logic [AW-1:0]   op_rm,
  input  logic [IDXW-1:0] op_idx,
  input  logic [SW-1:0]   op_scalar,
  input  logic [AW-1:0]   dbg_addr,
  output logic [VW-1:0]   dbg_data,
  output logic            err
);

  simd_op_e      op;
  logic [1:0]    size;
  logic [2:0]    lg;
  int            total_bits;
  int            lane_cnt;
  logic          arr_ok;
  logic          idx_ok;
  logic          legal;
  logic          narrow;
  logic          wr_en;
  logic [VW-1:0] src_a, src_b, rd_old, wr_data;

  assign op         = simd_op_e'(op_code);
  assign size       = op_arr[4:3];
  assign lg         = op_arr[2:0];
  assign total_bits = arr_bits(size, lg);
  assign lane_cnt   = 1 << lg;
  assign arr_ok     = (total_bits == VW) || (total_bits == VW / 2);
  assign idx_ok     = !uses_index(op) || (int'(op_idx) < lane_cnt);
  assign legal      = arr_ok && idx_ok;
  assign narrow     = (total_bits == VW / 2);
  assign wr_en      = op_valid && legal;

  simd_vrf #(.VW(VW), .DEPTH(DEPTH)) u_vrf (
    .clk      (clk),
    .rst      (rst),
    .we       (wr_en),
    .waddr    (op_rd),
    .wdata    (wr_data),
    .ra_addr  (op_rn),
    .ra_data  (src_a),
    .rb_addr  (op_rm),
    .rb_data  (src_b),
    .rc_addr  (op_rd),
    .rc_data  (rd_old),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  simd_lane_alu #(.VW(VW), .IDXW(IDXW), .SW(SW)) u_alu (
    .op      (op),
    .size    (size),
    .narrow  (narrow),
    .idx     (op_idx),
    .scalar  (op_scalar),
    .src_a   (src_a),
    .src_b   (src_b),
    .dst_old (rd_old),
    .result  (wr_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err <= 1'b0;
    end else begin
      err <= op_valid && !legal;
    end
  end

endmodule

// File: rtl/simd_regunit_chk.sv
module simd_regunit_chk #(
  parameter int VW   = 128,
  parameter int IDXW = 4,
  parameter int SW   = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            op_valid,
  input logic [1:0]      op_code,
  input logic [4:0]      op_arr,
  input logic [IDXW-1:0] op_idx,
  input logic [SW-1:0]   op_scalar,
  input logic            err,
  input logic            wr_en,
  input logic [VW-1:0]   wr_data,
  input logic [VW-1:0]   rd_old
);

  int            w_c, n_c, tot_c, pos_c;
  logic          ok_c, narrow_c, is_ins;
  logic [VW-1:0] lowm, emask, scx;

  assign w_c      = 8 << op_arr[4:3];
  assign n_c      = 1 << op_arr[2:0];
  assign tot_c    = w_c * n_c;
  assign pos_c    = int'(op_idx) * w_c;
  assign is_ins   = (op_code == 2'd3);
  assign ok_c     = ((tot_c == VW) || (tot_c == VW / 2)) &&
                    !((op_code[1] == 1'b1) && (int'(op_idx) >= n_c));
  assign narrow_c = (tot_c == VW / 2);
  assign lowm     = {VW{1'b1}} >> (VW - w_c);
  assign emask    = lowm << pos_c;
  assign scx      = VW'(op_scalar);

  // R2
  illegal_err_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ok_c) |=> err);

  // R2
  no_write_on_illegal_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ok_c) |-> !wr_en);

  // R10
  quiet_err_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || ok_c) |=> !err);

  // R7
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && narrow_c && !is_ins) |-> (wr_data[VW-1:VW/2] == '0));

  // R6
  insert_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_ins) |-> (((wr_data ^ rd_old) & ~emask) == '0));

  // R6
  insert_value_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && is_ins) |-> (((wr_data >> pos_c) & lowm) == (scx & lowm)));

endmodule

bind simd_regunit simd_regunit_chk #(.VW(VW), .IDXW(IDXW), .SW(SW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .op_arr    (op_arr),
  .op_idx    (op_idx),
  .op_scalar (op_scalar),
  .err       (err),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_old    (rd_old)
);

// File: tb/tb_simd_regunit.sv
module tb_simd_regunit;

  localparam int VW    = 128;
  localparam int DEPTH = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [1:0]    op_code = '0;
  logic [4:0]    op_arr = '0;
  logic [4:0]    op_rd = '0, op_rn = '0, op_rm = '0;
  logic [3:0]    op_idx = '0;
  logic [63:0]   op_scalar = '0;
  logic [4:0]    dbg_addr = '0;
  logic [VW-1:0] dbg_data;
  logic          err;

  logic [VW-1:0] mref [DEPTH];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  simd_regunit #(.VW(VW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .op_arr(op_arr), .op_rd(op_rd), .op_rn(op_rn), .op_rm(op_rm),
    .op_idx(op_idx), .op_scalar(op_scalar), .dbg_addr(dbg_addr),
    .dbg_data(dbg_data), .err(err)
  );

  task automatic chk(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] model(input logic [1:0] op, input logic [4:0] arr,
      input logic [VW-1:0] a, input logic [VW-1:0] b, input logic [VW-1:0] d,
      input logic [3:0] idx, input logic [63:0] sc, output bit ok);
    int w = 8 << arr[4:3];
    int n = 1 << arr[2:0];
    int tot = w * n;
    logic [VW-1:0] m = {VW{1'b1}} >> (VW - w);
    logic [VW-1:0] r = '0;
    logic [VW-1:0] ea, eb, val;
    ok = ((tot == VW) || (tot == VW / 2)) && !((op >= 2) && (int'(idx) >= n));
    if (!ok) return d;
    if (op == 2'd3) begin
      r = (d & ~(m << (int'(idx) * w))) | ((VW'(sc) & m) << (int'(idx) * w));
    end else begin
      for (int k = 0; k < VW / w; k++) begin
        ea = (a >> (k * w)) & m;
        eb = (op == 2'd2) ? ((b >> (int'(idx) * w)) & m) : ((b >> (k * w)) & m);
        val = (op == 2'd0) ? (ea + eb) : (ea * eb);
        r = r | ((val & m) << (k * w));
      end
      if (tot == VW / 2) r = r & ({VW{1'b1}} >> (VW / 2));
    end
    return r;
  endfunction

  // One cycle: drive, predict, sample after the edge, compare, update the model.
  task automatic step(input bit v, input logic [1:0] op, input logic [4:0] arr,
      input logic [4:0] rd, input logic [4:0] rn, input logic [4:0] rm,
      input logic [3:0] idx, input logic [63:0] sc, input logic [4:0] da, input string tag);
    logic [VW-1:0] exp_dbg, res;
    bit ok;
    @(negedge clk);
    op_valid = v; op_code = op; op_arr = arr; op_rd = rd; op_rn = rn; op_rm = rm;
    op_idx = idx; op_scalar = sc; dbg_addr = da;
    exp_dbg = mref[da];
    res = model(op, arr, mref[rn], mref[rm], mref[rd], idx, sc, ok);
    @(posedge clk);
    #1;
    chk({tag, " R9 dbg"}, dbg_data, exp_dbg);
    if (v && !ok) chk("R2 err", VW'(err), VW'(1));
    else          chk("R10 err", VW'(err), VW'(0));
    if (v && ok) mref[rd] = res;
  endtask

  task automatic idle(input logic [4:0] da, input string tag);
    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'd0, 4'd0, 64'd0, da, tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mref[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every register reads zero after reset
    for (int i = 0; i < DEPTH; i++) idle(5'(i), "R1");
    idle(5'd31, "R1");
    chk("R1 last reg", dbg_data, '0);

    // R6 / R8: fill every register with two 64-bit inserts
    for (int r = 0; r < DEPTH; r++)
      for (int e = 0; e < 2; e++)
        step(1'b1, 2'd3, {2'd3, 3'd1}, 5'(r), 5'd0, 5'd0, 4'(e),
             {$urandom, $urandom}, 5'(r), "R6");

    // R3: byte lanes 0xFF + 0x01 must wrap to zero with no carry across lanes
    for (int e = 0; e < 16; e++) begin
      step(1'b1, 2'd3, {2'd0, 3'd4}, 5'd1, 5'd0, 5'd0, 4'(e), 64'hFF, 5'd1, "R8");
      step(1'b1, 2'd3, {2'd0, 3'd4}, 5'd2, 5'd0, 5'd0, 4'(e), 64'h01, 5'd2, "R8");
    end
    step(1'b1, 2'd0, {2'd0, 3'd4}, 5'd3, 5'd1, 5'd2, 4'd0, 64'd0, 5'd3, "R3");
    idle(5'd3, "R3");
    chk("R3 lane wrap", dbg_data, '0);

    // R8: halfword element 2 occupies bits 47:32
    step(1'b1, 2'd3, {2'd1, 3'd3}, 5'd3, 5'd0, 5'd0, 4'd2, 64'h1234, 5'd3, "R8");
    idle(5'd3, "R8");
    chk("R8 position", dbg_data, VW'(128'h1234) << 32);

    // R4 / R5: multiply and by-element multiply on 16- and 32-bit lanes
    step(1'b1, 2'd1, {2'd1, 3'd3}, 5'd10, 5'd4, 5'd5, 4'd0, 64'd0, 5'd10, "R4");
    step(1'b1, 2'd2, {2'd2, 3'd2}, 5'd11, 5'd6, 5'd7, 4'd3, 64'd0, 5'd10, "R5");
    step(1'b1, 2'd2, {2'd0, 3'd4}, 5'd12, 5'd6, 5'd7, 4'd15, 64'd0, 5'd11, "R5");
    idle(5'd12, "R5");

    // R5: index 5 with four halfword lanes is out of range
    step(1'b1, 2'd2, {2'd1, 3'd2}, 5'd13, 5'd6, 5'd7, 4'd5, 64'd0, 5'd13, "R5");
    idle(5'd13, "R5");

    // R7: 2x32 add clears the top half of the destination
    step(1'b1, 2'd0, {2'd2, 3'd1}, 5'd14, 5'd8, 5'd9, 4'd0, 64'd0, 5'd14, "R7");
    idle(5'd14, "R7");
    chk("R7 upper zero", dbg_data >> 64, '0);
    step(1'b1, 2'd1, {2'd3, 3'd0}, 5'd15, 5'd8, 5'd9, 4'd0, 64'd0, 5'd15, "R7");
    idle(5'd15, "R7");

    // R2: 32-bit and 256-bit totals are rejected; the register is unchanged
    step(1'b1, 2'd0, {2'd0, 3'd2}, 5'd16, 5'd8, 5'd9, 4'd0, 64'd0, 5'd16, "R2");
    step(1'b1, 2'd1, {2'd3, 3'd2}, 5'd16, 5'd8, 5'd9, 4'd0, 64'd0, 5'd16, "R2");
    step(1'b1, 2'd3, {2'd2, 3'd1}, 5'd16, 5'd0, 5'd0, 4'd2, 64'hDEAD, 5'd16, "R6");
    idle(5'd16, "R2");

    // R9: back-to-back dependent operations and read of the just-written register
    step(1'b1, 2'd0, {2'd0, 3'd4}, 5'd20, 5'd17, 5'd18, 4'd0, 64'd0, 5'd20, "R9");
    step(1'b1, 2'd0, {2'd0, 3'd4}, 5'd21, 5'd20, 5'd20, 4'd0, 64'd0, 5'd20, "R9");
    step(1'b1, 2'd1, {2'd3, 3'd1}, 5'd21, 5'd21, 5'd20, 4'd0, 64'd0, 5'd21, "R9");
    idle(5'd21, "R9");

    // Random mix of every opcode, arrangement and index
    for (int t = 0; t < 600; t++) begin
      logic [1:0] op = 2'($urandom);
      string tg = (op == 2'd0) ? "R3" : (op == 2'd1) ? "R4" : (op == 2'd2) ? "R5" : "R6";
      step(($urandom % 5) != 0, op, 5'($urandom), 5'($urandom), 5'($urandom),
           5'($urandom), 4'($urandom), {$urandom, $urandom}, 5'($urandom), tg);
    end

    for (int i = 0; i < DEPTH; i++) idle(5'(i), "R9");
    idle(5'd0, "R9");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule